// File: doc/BRIEF.md
# Lockstep Run Outcome Classifier

This block sits next to a fault-injected design and a replayed golden trace. Every cycle of a run it compares the output bus of the design under test with the reference bus. It watches each memory access for addresses outside the program's image, and it watches for abnormal exceptions, program completion and the run time. When the run ends it reports one outcome category. It also reports whether the fault ever became visible at the outputs and how many cycles the fault took to surface.

A run begins with a one-cycle `run_start` pulse. The pulse latches the golden cycle count and numbers the first running cycle as 0. The harness marks the cycle in which the fault is injected with `inject`. The final architectural state and memory comparison arrives on `state_ok` together with `prog_done`. The verdict is registered and announced by a one-cycle `result_valid` pulse. The category, flag and latency outputs hold their values until the next verdict replaces them.

Top module: `lockstep_outcome_classifier`

## Requirements
- R1: After reset, `result_valid` is 0, `category` is 0, `manifested` is 0 and `latency` is all ones.
- R2: An output difference counts only while a run is active and only from the injection cycle onward. Any such difference in a cycle up to and including the decisive cycle sets `manifested`.
- R3: `latency` equals the run cycle of the first counted difference minus the run cycle of the first `inject` pulse. It reads all ones when there was no counted difference.
- R4: A valid access on any access port whose address is below `img_lo` or above `img_hi` ends the run in that cycle with category 4 (crash). Both bounds are inclusive limits of the legal range.
- R5: `exc_flag` during a run ends it in that cycle with category 4 (crash).
- R6: The time limit is G + ((G*13) >> 7), where G is the golden count latched at start. The limit saturates at the largest count. If run cycle number limit is reached without `prog_done`, the run ends with category 3 (incomplete).
- R7: `prog_done` with `state_ok` low ends the run with category 2 (silent data corruption).
- R8: `prog_done` with `state_ok` high gives category 1 (no effect) if `manifested`, otherwise category 0 (masked).
- R9: When several end conditions occur in one cycle, the precedence is crash, then incomplete, then silent corruption, then no effect, then masked. `prog_done` in the limit cycle counts as a finish.
- R10: `result_valid` is high for exactly the one cycle after the decisive cycle. The outputs hold until the next verdict.
- R11: While no run is active, mismatches, accesses, exceptions and done flags produce no result and change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_start | input | 1 | Starts (or restarts) a run |
| golden_cycles | input | CYC_W | Reference run length, latched at start |
| inject | input | 1 | Fault injection happens this cycle |
| dut_bus | input | OUT_W | Output bus of the faulty design |
| ref_bus | input | OUT_W | Output bus from the golden trace |
| acc_valid | input | ACC_PORTS | Per-port memory access valid |
| acc_addr | input | ACC_PORTS*ADDR_W | Per-port access address, port 0 in the low bits |
| img_lo | input | ADDR_W | Lowest legal address |
| img_hi | input | ADDR_W | Highest legal address |
| exc_flag | input | 1 | Abnormal exception raised |
| prog_done | input | 1 | Program finished |
| state_ok | input | 1 | Final state equals golden state |
| result_valid | output | 1 | One-cycle verdict strobe |
| category | output | 3 | 0 masked, 1 no effect, 2 SDC, 3 incomplete, 4 crash |
| manifested | output | 1 | A counted output difference occurred |
| latency | output | CYC_W | Injection-to-first-difference cycles |

## Verification
Several end conditions can land in the same cycle, and the bench sets them up on purpose. One run drives an exception together with `prog_done` and expects a crash rather than a finish. Another run completes exactly in the limit cycle and must be judged masked, not incomplete. A third places an output difference in the finishing cycle itself and expects no effect with that cycle's latency. In each case the run is judged by the category, the flag, the latency and the cycle in which the strobe appears.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    typedef enum logic [2:0] {
        OUT_MASKED   = 3'd0,
        OUT_NOEFFECT = 3'd1,
        OUT_SDC      = 3'd2,
        OUT_HANG     = 3'd3,
        OUT_CRASH    = 3'd4
    } outcome_e;

    typedef struct packed {
        logic     finish;
        outcome_e kind;
    } verdict_t;

    localparam int unsigned MARGIN_MUL   = 13;
    localparam int unsigned MARGIN_SHIFT = 7;
    localparam int unsigned MARGIN_BITS  = 4;

    function automatic logic outside_range(input logic [63:0] a,
                                           input logic [63:0] lo,
                                           input logic [63:0] hi);
        return (a < lo) || (a > hi);
    endfunction

endpackage

// File: rtl/lsc_budget.sv
module lsc_budget #(
    parameter int CYC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CYC_W-1:0] golden_in,
    output logic [CYC_W-1:0] limit_o
);
    import lsc_pkg::*;

    localparam int WIDE_W = CYC_W + MARGIN_BITS + 1;

    logic [CYC_W-1:0]  golden_q;
    logic [WIDE_W-1:0] scaled;
    logic [WIDE_W-1:0] margin;
    logic [WIDE_W-1:0] total;

    always_ff @(posedge clk) begin
        if (rst) begin
            golden_q <= '0;
        end else if (load) begin
            golden_q <= golden_in;
        end
    end

    always_comb begin
        scaled = WIDE_W'(golden_q) * WIDE_W'(MARGIN_MUL);
        margin = scaled >> MARGIN_SHIFT;
        total  = WIDE_W'(golden_q) + margin;
        if (total > WIDE_W'({CYC_W{1'b1}})) begin
            limit_o = '1;
        end else begin
            limit_o = total[CYC_W-1:0];
        end
    end

endmodule

// File: rtl/lsc_access_guard.sv
module lsc_access_guard #(
    parameter int ADDR_W    = 32,
    parameter int ACC_PORTS = 2
) (
    input  logic                        active,
    input  logic [ACC_PORTS-1:0]        acc_valid,
    input  logic [ACC_PORTS*ADDR_W-1:0] acc_addr,
    input  logic [ADDR_W-1:0]           img_lo,
    input  logic [ADDR_W-1:0]           img_hi,
    input  logic                        exc_flag,
    output logic                        crash_o
);
    import lsc_pkg::*;

    logic [ACC_PORTS-1:0] port_bad;

    for (genvar p = 0; p < ACC_PORTS; p++) begin : g_port
        logic [ADDR_W-1:0] a;
        assign a = acc_addr[p*ADDR_W +: ADDR_W];
        assign port_bad[p] = acc_valid[p] &&
                             outside_range(64'(a), 64'(img_lo), 64'(img_hi));
    end

    assign crash_o = active && ((|port_bad) || exc_flag);

endmodule

// File: rtl/lsc_mismatch_track.sv
module lsc_mismatch_track #(
    parameter int OUT_W = 32,
    parameter int CYC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             active,
    input  logic             inject,
    input  logic [CYC_W-1:0] cnt,
    input  logic [OUT_W-1:0] dut_bus,
    input  logic [OUT_W-1:0] ref_bus,
    output logic             seen_d,
    output logic [CYC_W-1:0] lat_d
);
    logic             inj_seen;
    logic [CYC_W-1:0] inj_cyc;
    logic             mm_seen;
    logic [CYC_W-1:0] mm_lat;
    logic             armed;
    logic [CYC_W-1:0] inj_eff;
    logic             hit;
    logic [OUT_W-1:0] diff;

    assign diff    = dut_bus ^ ref_bus;
    assign armed   = inj_seen || (active && inject);
    assign inj_eff = inj_seen ? inj_cyc : cnt;
    assign hit     = active && armed && (|diff);
    assign seen_d  = mm_seen || hit;
    assign lat_d   = mm_seen ? mm_lat : (cnt - inj_eff);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            inj_seen <= 1'b0;
            inj_cyc  <= '0;
            mm_seen  <= 1'b0;
            mm_lat   <= '0;
        end else if (active) begin
            if (inject && !inj_seen) begin
                inj_seen <= 1'b1;
                inj_cyc  <= cnt;
            end
            if (hit && !mm_seen) begin
                mm_seen <= 1'b1;
                mm_lat  <= cnt - inj_eff;
            end
        end
    end

endmodule

// File: rtl/lsc_verdict.sv
module lsc_verdict (
    input  logic                active,
    input  logic                crash,
    input  logic                at_limit,
    input  logic                done,
    input  logic                state_ok,
    input  logic                manifest,
    output lsc_pkg::verdict_t   verdict_o
);
    import lsc_pkg::*;

    always_comb begin
        verdict_o.finish = 1'b0;
        verdict_o.kind   = OUT_MASKED;
        if (active) begin
            if (crash) begin
                verdict_o.finish = 1'b1;
                verdict_o.kind   = OUT_CRASH;
            end else if (!done && at_limit) begin
                verdict_o.finish = 1'b1;
                verdict_o.kind   = OUT_HANG;
            end else if (done && !state_ok) begin
                verdict_o.finish = 1'b1;
                verdict_o.kind   = OUT_SDC;
            end else if (done) begin
                verdict_o.finish = 1'b1;
                verdict_o.kind   = manifest ? OUT_NOEFFECT : OUT_MASKED;
            end
        end
    end

endmodule

// File: rtl/lockstep_outcome_classifier.sv
module lockstep_outcome_classifier #(
    parameter int OUT_W     = 32,
    parameter int ADDR_W    = 32,
    parameter int ACC_PORTS = 2,
    parameter int CYC_W     = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        run_start,
    input  logic [CYC_W-1:0]            golden_cycles,
    input  logic                        inject,
    input  logic [OUT_W-1:0]            dut_bus,
    input  logic [OUT_W-1:0]            ref_bus,
    input  logic [ACC_PORTS-1:0]        acc_valid,
    input  logic [ACC_PORTS*ADDR_W-1:0] acc_addr,
    input  logic [ADDR_W-1:0]           img_lo,
    input  logic [ADDR_W-1:0]           img_hi,
    input  logic                        exc_flag,
    input  logic                        prog_done,
    input  logic                        state_ok,
    output logic                        result_valid,
    output logic [2:0]                  category,
    output logic                        manifested,
    output logic [CYC_W-1:0]            latency
);
    import lsc_pkg::*;

    logic             run_active;
    logic [CYC_W-1:0] cyc_cnt;
    logic [CYC_W-1:0] limit;
    logic             crash;
    logic             seen_d;
    logic [CYC_W-1:0] lat_d;
    verdict_t         verdict;
    outcome_e         res_kind;

    lsc_budget #(.CYC_W(CYC_W)) u_budget (
        .clk       (clk),
        .rst       (rst),
        .load      (run_start),
        .golden_in (golden_cycles),
        .limit_o   (limit)
    );

    lsc_access_guard #(.ADDR_W(ADDR_W), .ACC_PORTS(ACC_PORTS)) u_guard (
        .active    (run_active),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .img_lo    (img_lo),
        .img_hi    (img_hi),
        .exc_flag  (exc_flag),
        .crash_o   (crash)
    );

    lsc_mismatch_track #(.OUT_W(OUT_W), .CYC_W(CYC_W)) u_track (
        .clk     (clk),
        .rst     (rst),
        .clear   (run_start),
        .active  (run_active),
        .inject  (inject),
        .cnt     (cyc_cnt),
        .dut_bus (dut_bus),
        .ref_bus (ref_bus),
        .seen_d  (seen_d),
        .lat_d   (lat_d)
    );

    lsc_verdict u_verdict (
        .active    (run_active),
        .crash     (crash),
        .at_limit  (cyc_cnt == limit),
        .done      (prog_done),
        .state_ok  (state_ok),
        .manifest  (seen_d),
        .verdict_o (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            run_active   <= 1'b0;
            cyc_cnt      <= '0;
            result_valid <= 1'b0;
            res_kind     <= OUT_MASKED;
            manifested   <= 1'b0;
            latency      <= '1;
        end else begin
            result_valid <= 1'b0;
            if (run_start) begin
                run_active <= 1'b1;
                cyc_cnt    <= '0;
            end else if (run_active) begin
                if (verdict.finish) begin
                    run_active   <= 1'b0;
                    result_valid <= 1'b1;
                    res_kind     <= verdict.kind;
                    manifested   <= seen_d;
                    latency      <= seen_d ? lat_d : '1;
                end else begin
                    cyc_cnt <= cyc_cnt + 1'b1;
                end
            end
        end
    end

    assign category = res_kind;

endmodule

// File: rtl/lsc_checker.sv
module lsc_checker #(
    parameter int ADDR_W    = 32,
    parameter int ACC_PORTS = 2,
    parameter int CYC_W     = 16
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        run_active,
    input logic [ACC_PORTS-1:0]        acc_valid,
    input logic [ACC_PORTS*ADDR_W-1:0] acc_addr,
    input logic [ADDR_W-1:0]           img_lo,
    input logic [ADDR_W-1:0]           img_hi,
    input logic                        exc_flag,
    input logic                        prog_done,
    input logic                        result_valid,
    input logic [2:0]                  category,
    input logic                        manifested,
    input logic [CYC_W-1:0]            latency
);
    logic any_out;

    always_comb begin
        any_out = 1'b0;
        for (int p = 0; p < ACC_PORTS; p++) begin
            if (acc_valid[p] && ((acc_addr[p*ADDR_W +: ADDR_W] < img_lo) ||
                                 (acc_addr[p*ADDR_W +: ADDR_W] > img_hi)))
                any_out = 1'b1;
        end
    end

    assert_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

    assert_code_range_R10: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> (category <= 3'd4));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !run_active |=> !result_valid);

    assert_bounds_crash_R4: assert property (@(posedge clk) disable iff (rst)
        (run_active && any_out) |=> (result_valid && category == 3'd4));

    assert_exc_crash_R5: assert property (@(posedge clk) disable iff (rst)
        (run_active && exc_flag) |=> (result_valid && category == 3'd4));

    assert_done_ends_R7: assert property (@(posedge clk) disable iff (rst)
        (run_active && prog_done) |=> result_valid);

    assert_no_latency_R3: assert property (@(posedge clk) disable iff (rst)
        (result_valid && !manifested) |-> (&latency));

    assert_masked_clean_R8: assert property (@(posedge clk) disable iff (rst)
        (result_valid && category == 3'd0) |-> !manifested);

    assert_noeffect_seen_R8: assert property (@(posedge clk) disable iff (rst)
        (result_valid && category == 3'd1) |-> manifested);

endmodule

bind lockstep_outcome_classifier lsc_checker #(
    .ADDR_W    (ADDR_W),
    .ACC_PORTS (ACC_PORTS),
    .CYC_W     (CYC_W)
) u_lsc_checker (
    .clk          (clk),
    .rst          (rst),
    .run_active   (run_active),
    .acc_valid    (acc_valid),
    .acc_addr     (acc_addr),
    .img_lo       (img_lo),
    .img_hi       (img_hi),
    .exc_flag     (exc_flag),
    .prog_done    (prog_done),
    .result_valid (result_valid),
    .category     (category),
    .manifested   (manifested),
    .latency      (latency)
);

// File: tb/test_lockstep_outcome_classifier.sv
module test_lockstep_outcome_classifier;

    localparam int  PERIOD = 10;
    localparam int  OUT_W  = 8;
    localparam int  ADDR_W = 16;
    localparam int  NPORT  = 2;
    localparam int  CYC_W  = 10;
    localparam int  MAXC   = (1 << CYC_W) - 1;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    run_start = 1'b0;
    logic [CYC_W-1:0]        golden_cycles = '0;
    logic                    inject = 1'b0;
    logic [OUT_W-1:0]        dut_bus = '0;
    logic [OUT_W-1:0]        ref_bus = '0;
    logic [NPORT-1:0]        acc_valid = '0;
    logic [NPORT*ADDR_W-1:0] acc_addr = '0;
    logic [ADDR_W-1:0]       img_lo = 16'h1000;
    logic [ADDR_W-1:0]       img_hi = 16'h1FFF;
    logic                    exc_flag = 1'b0;
    logic                    prog_done = 1'b0;
    logic                    state_ok = 1'b1;
    logic                    result_valid;
    logic [2:0]              category;
    logic                    manifested;
    logic [CYC_W-1:0]        latency;

    int n_checks = 0;
    int n_fail   = 0;

    always #(PERIOD/2) clk = ~clk;

    lockstep_outcome_classifier #(
        .OUT_W(OUT_W), .ADDR_W(ADDR_W), .ACC_PORTS(NPORT), .CYC_W(CYC_W)
    ) i_lockstep_outcome_classifier (
        .clk(clk), .rst(rst), .run_start(run_start), .golden_cycles(golden_cycles),
        .inject(inject), .dut_bus(dut_bus), .ref_bus(ref_bus),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .img_lo(img_lo), .img_hi(img_hi),
        .exc_flag(exc_flag), .prog_done(prog_done), .state_ok(state_ok),
        .result_valid(result_valid), .category(category),
        .manifested(manifested), .latency(latency)
    );

    task automatic check_eq(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int limit_of(int g);
        int l;
        l = g + ((g * 13) >> 7);
        return (l > MAXC) ? MAXC : l;
    endfunction

    task automatic idle_inputs();
        inject = 0; dut_bus = '0; ref_bus = '0; acc_valid = '0; acc_addr = '0;
        exc_flag = 0; prog_done = 0; state_ok = 1;
    endtask

    // One run: event cycles are run cycle numbers, -1 means never.
    task automatic do_run(string tag, int g, int inj, int mm, int mmlen,
                          int acc_c, int acc_p, logic [ADDR_W-1:0] acc_a,
                          int exc_c, int done_c, bit st_ok,
                          int e_cat, int e_man, int e_lat, int e_end);
        int end_c = -1;
        @(negedge clk);
        run_start = 1; golden_cycles = CYC_W'(g);
        @(negedge clk);
        run_start = 0;
        for (int c = 0; c < 1200; c++) begin
            ref_bus   = OUT_W'(c);
            dut_bus   = (mm >= 0 && c >= mm && c < mm + mmlen) ? (OUT_W'(c) ^ 8'h01) : OUT_W'(c);
            inject    = (c == inj);
            acc_valid = '0;
            acc_addr  = '0;
            if (c == acc_c) begin
                acc_valid[acc_p] = 1'b1;
                acc_addr[acc_p*ADDR_W +: ADDR_W] = acc_a;
            end
            exc_flag  = (c == exc_c);
            prog_done = (c == done_c);
            state_ok  = st_ok;
            @(negedge clk);
            if (result_valid) begin
                end_c = c;
                break;
            end
        end
        idle_inputs();
        check_eq({tag, " end cycle"}, end_c, e_end);
        check_eq({tag, " category"}, int'(category), e_cat);
        check_eq({tag, " manifested"}, int'(manifested), e_man);
        check_eq({tag, " latency"}, int'(latency), e_lat);
        @(negedge clk);
        check_eq({tag, " R10 strobe one cycle"}, int'(result_valid), 0);
        check_eq({tag, " R10 hold category"}, int'(category), e_cat);
    endtask

    task automatic t_reset();
        check_eq("R1 result_valid", int'(result_valid), 0);
        check_eq("R1 category", int'(category), 0);
        check_eq("R1 manifested", int'(manifested), 0);
        check_eq("R1 latency", int'(latency), MAXC);
    endtask

    task automatic t_masked();
        do_run("R8 masked", 40, 3, -1, 0, -1, 0, '0, -1, 20, 1, 0, 0, MAXC, 20);
    endtask

    task automatic t_noeffect();
        do_run("R8 R3 no effect", 40, 5, 9, 2, -1, 0, '0, -1, 30, 1, 1, 1, 4, 30);
        do_run("R2 R9 mismatch in done cycle", 40, 4, 15, 1, -1, 0, '0, -1, 15, 1, 1, 1, 11, 15);
    endtask

    task automatic t_sdc();
        do_run("R7 sdc with mismatch", 40, 2, 2, 1, -1, 0, '0, -1, 25, 0, 2, 1, 0, 25);
        do_run("R7 sdc silent", 40, 2, -1, 0, -1, 0, '0, -1, 25, 0, 2, 0, MAXC, 25);
    endtask

    task automatic t_crash_bounds();
        do_run("R4 below image", 40, 1, 4, 1, 7, 0, 16'h0FFF, -1, 30, 1, 4, 1, 3, 7);
        do_run("R4 above image", 40, 1, -1, 0, 11, 1, 16'h2000, -1, 30, 1, 4, 0, MAXC, 11);
        do_run("R4 low bound legal", 40, 1, -1, 0, 3, 0, 16'h1000, -1, 15, 1, 0, 0, MAXC, 15);
        do_run("R4 high bound legal", 40, 1, -1, 0, 3, 1, 16'h1FFF, -1, 15, 1, 0, 0, MAXC, 15);
    endtask

    task automatic t_exception();
        do_run("R5 exception", 40, 0, -1, 0, -1, 0, '0, 6, 30, 1, 4, 0, MAXC, 6);
        do_run("R9 exception beats done", 40, 0, -1, 0, -1, 0, '0, 10, 10, 0, 4, 0, MAXC, 10);
    endtask

    task automatic t_timeout();
        do_run("R6 timeout", 40, 2, -1, 0, -1, 0, '0, -1, -1, 1, 3, 0, MAXC, limit_of(40));
        do_run("R9 done at limit", 40, 2, -1, 0, -1, 0, '0, -1, limit_of(40), 1, 0, 0, MAXC, limit_of(40));
        do_run("R6 limit saturates", 1000, 2, 5, 1, -1, 0, '0, -1, -1, 1, 3, 1, 3, limit_of(1000));
    endtask

    task automatic t_pre_inject();
        do_run("R2 mismatch before inject", 40, 5, 2, 2, -1, 0, '0, -1, 12, 1, 0, 0, MAXC, 12);
    endtask

    task automatic t_idle();
        int seen = 0;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            dut_bus = 8'hAA; ref_bus = 8'h55; inject = 1; exc_flag = 1; prog_done = 1;
            state_ok = 0; acc_valid = 2'b11; acc_addr = '0;
            @(negedge clk);
            if (result_valid) seen++;
        end
        idle_inputs();
        check_eq("R11 idle no strobe", seen, 0);
        check_eq("R11 idle category held", int'(category), 0);
        check_eq("R11 idle latency held", int'(latency), MAXC);
        do_run("R11 run after idle", 40, -1, -1, 0, -1, 0, '0, -1, 8, 1, 0, 0, MAXC, 8);
    endtask

    initial begin
        #(PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_masked();
        t_noeffect();
        t_sdc();
        t_crash_bounds();
        t_exception();
        t_timeout();
        t_pre_inject();
        do_run("R8 clean before idle", 40, 1, -1, 0, -1, 0, '0, -1, 5, 1, 0, 0, MAXC, 5);
        t_idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule